// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is the counter/timer that sits next to one processor. It has two personalities, and an external mode level selects between them. In counter mode it counts ticks up to a programmable limit, sets a reached flag and raises an interrupt on each wrap, and restarts from zero. A limit of zero makes it free-run over its full range with no match. In user mode the same storage becomes a 63-bit up-counter. Software reads and loads it as two 32-bit words, starts and stops it with a run bit, and it never interrupts.

Software reaches the block through a four-word register window: word index, write strobe, write data, and registered read data. A tick enable advances the count by one step of 512 count units, so the low nine bits of every count value are zero. Mode changes arrive as a one-cycle strobe that carries the new level. The block carries out the transition actions itself, but only when the level really differs from the current mode.

Top module: `proc_timer`

## Requirements
- R1: After reset the block is in counter mode with limit 0, count 0, run bit 1, reached flag 0 and `irq` low.
- R2: In counter mode with a limit of N ticks, written as bits 30..9 of word 0, the count goes 0,1,..,N-1 on enabled ticks and then wraps to 0. At the wrap it sets the reached flag and raises `irq`. Word 1 reads as {reached, count[21:0], 9'b0}. Writing word 0 also clears the count to 0 and lowers `irq`.
- R3: In counter mode with limit 0 the count wraps from 0x3FFFFE ticks to 0, and the wrap sets neither the reached flag nor `irq`.
- R4: In counter mode, a read of word 0 returns {1'b0, limit, 9'b0} and clears both the reached flag and `irq`. A write to word 2 changes the limit and leaves the count where it was.
- R5: In user mode, word 0 reads as {reached, count[62:32]} and word 1 reads as {count[31:9], 9'b0}. `irq` stays low throughout user mode.
- R6: In user mode, a write to word 0 loads count bits 62..32 from data bits 30..0. A write to word 1 loads count bits 31..9 from data bits 31..9. Either write clears the reached flag, and counting continues from the combined value.
- R7: In user mode the count wraps to 0 on the tick that follows the value 0x7FFFFFFFFFFFFC00. The wrap sets the reached flag and leaves `irq` low.
- R8: Bit 0 of word 3 is the run bit, and a read returns it in bit 0 with all other bits 0. In user mode, run=0 freezes the count and run=1 lets it advance. In counter mode the count advances whatever the run bit holds.
- R9: A mode strobe acts only when its level differs from the current mode. Entering user mode lowers `irq` and keeps the count. Returning to counter mode resumes counting even when the run bit is 0.
- R10: In user mode, a read of word 0 captures the lower count word. The next read of word 1 returns the captured value, even if ticks have carried between the two halves in the meantime.
- R11: Read data and `bus_rvalid` appear on the cycle after the read request. Word 2 reads as 0. A write to word 1 in counter mode has no effect, and a write to word 2 in user mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Advance the count by one tick this cycle |
| mode_stb | input | 1 | One-cycle strobe: new mode level present |
| mode_user | input | 1 | New mode level, 1 = user mode |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Word index within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| irq | output | 1 | Counter-mode match interrupt, level |

## Verification
A wrong count or a wrong wrap point shows up at the very next read of word 1 or word 0. In counter mode it also shows up as an `irq` edge in the wrong cycle. A mode register that is out of step with the strobe shows as an `irq` that fails to drop or appears in user mode, and as a run bit that freezes or fails to freeze the count over the following ticks. A stale capture register shows as a lower word that does not match the high half read just before it. The bench checks `irq` after every operation, so a fault in the reached or interrupt state is seen within one operation of its cause.

// File: rtl/proc_timer_pkg.sv
package proc_timer_pkg;
   typedef enum logic [1:0] {
      WORD_HI_LIM   = 2'd0,
      WORD_LO_CNT   = 2'd1,
      WORD_LIM_KEEP = 2'd2,
      WORD_CTRL     = 2'd3
   } ptc_word_e;
endpackage

// File: rtl/proc_timer_mode.sv
module proc_timer_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_stb,
   input  logic mode_user,
   output logic usr,
   output logic chg,
   output logic to_user
);
   logic usr_q;

   assign chg     = mode_stb && (mode_user != usr_q);
   assign to_user = chg && mode_user;
   assign usr     = usr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   usr_q <= 1'b0;
      else if (chg) usr_q <= mode_user;
   end
endmodule

// File: rtl/proc_timer_count.sv
module proc_timer_count #(
   parameter int USR_W = 54,
   parameter int CTR_W = 22,
   parameter int LO_TW = 23,
   parameter int HI_W  = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             usr,
   input  logic             ld_hi,
   input  logic             ld_lo,
   input  logic             clr,
   input  logic [HI_W-1:0]  hi_val,
   input  logic [LO_TW-1:0] lo_val,
   input  logic [CTR_W-1:0] lim,
   output logic [USR_W-1:0] ticks,
   output logic             hit
);
   localparam int PAD = USR_W - CTR_W;
   localparam logic [USR_W-1:0] USR_TOP  = {{(USR_W-1){1'b1}}, 1'b0};
   localparam logic [USR_W-1:0] FREE_TOP = {{PAD{1'b0}}, {(CTR_W-1){1'b1}}, 1'b0};

   logic [USR_W-1:0] ticks_q;
   logic [USR_W-1:0] top_c;
   logic             wrap;

   always_comb begin
      if (usr)             top_c = USR_TOP;
      else if (lim == '0)  top_c = FREE_TOP;
      else                 top_c = {{PAD{1'b0}}, lim} - USR_W'(1);
   end

   assign wrap  = adv && (ticks_q >= top_c);
   assign hit   = wrap && (usr || (lim != '0));
   assign ticks = ticks_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks_q <= '0;
      end else if (clr) begin
         ticks_q <= '0;
      end else if (ld_hi) begin
         ticks_q[USR_W-1:LO_TW] <= hi_val;
      end else if (ld_lo) begin
         ticks_q[LO_TW-1:0] <= lo_val;
      end else if (wrap) begin
         ticks_q <= '0;
      end else if (adv) begin
         ticks_q <= ticks_q + USR_W'(1);
      end
   end
endmodule

// File: rtl/proc_timer_regs.sv
module proc_timer_regs
   import proc_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SUB_BITS = 9,
   parameter int USR_W    = 54,
   parameter int CTR_W    = 22,
   parameter int LO_TW    = 23,
   parameter bit SNAP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [1:0]        bus_word,
   input  logic [CTR_W-1:0]  lim_val,
   input  logic              run_val,
   input  logic              usr,
   input  logic              chg,
   input  logic              to_user,
   input  logic              hit,
   input  logic [USR_W-1:0]  ticks,
   output logic [CTR_W-1:0]  lim,
   output logic              run,
   output logic              ld_hi,
   output logic              ld_lo,
   output logic              clr,
   output logic              irq,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   ptc_word_e         word;
   logic              wr, rd;
   logic              wr_w0, wr_w1, wr_w2, wr_w3, rd_w0, rd_w1;
   logic              reached_q, irq_q, run_q;
   logic [CTR_W-1:0]  lim_q;
   logic [LO_TW-1:0]  lo_rd;
   logic [DATA_W-1:0] rmux, rdata_q;
   logic              rvalid_q;

   assign word  = ptc_word_e'(bus_word);
   assign wr    = bus_sel && bus_we;
   assign rd    = bus_sel && !bus_we;
   assign wr_w0 = wr && (word == WORD_HI_LIM);
   assign wr_w1 = wr && (word == WORD_LO_CNT);
   assign wr_w2 = wr && (word == WORD_LIM_KEEP);
   assign wr_w3 = wr && (word == WORD_CTRL);
   assign rd_w0 = rd && (word == WORD_HI_LIM);
   assign rd_w1 = rd && (word == WORD_LO_CNT);

   assign ld_hi = wr_w0 && usr;
   assign ld_lo = wr_w1 && usr;
   assign clr   = wr_w0 && !usr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q     <= '0;
         run_q     <= 1'b1;
         reached_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         if ((wr_w0 || wr_w2) && !usr) lim_q <= lim_val;
         if (wr_w3) run_q <= run_val;
         if (hit)
            reached_q <= 1'b1;
         else if (ld_hi || ld_lo || (rd_w0 && !usr))
            reached_q <= 1'b0;
         if (to_user || clr || (rd_w0 && !usr))
            irq_q <= 1'b0;
         else if (hit && !usr)
            irq_q <= 1'b1;
      end
   end

   generate
      if (SNAP_EN) begin : g_snap
         logic [LO_TW-1:0] snap_q;
         logic             snap_vld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               snap_q     <= '0;
               snap_vld_q <= 1'b0;
            end else if (chg || wr_w0 || wr_w1 || (rd_w1 && usr)) begin
               snap_vld_q <= 1'b0;
            end else if (rd_w0 && usr) begin
               snap_q     <= ticks[LO_TW-1:0];
               snap_vld_q <= 1'b1;
            end
         end
         assign lo_rd = snap_vld_q ? snap_q : ticks[LO_TW-1:0];
      end else begin : g_live
         assign lo_rd = ticks[LO_TW-1:0];
      end
   endgenerate

   always_comb begin
      unique case (word)
         WORD_HI_LIM:   rmux = usr ? {reached_q, ticks[USR_W-1:LO_TW]}
                                   : {1'b0, lim_q, {SUB_BITS{1'b0}}};
         WORD_LO_CNT:   rmux = usr ? {lo_rd, {SUB_BITS{1'b0}}}
                                   : {reached_q, ticks[CTR_W-1:0], {SUB_BITS{1'b0}}};
         WORD_LIM_KEEP: rmux = '0;
         default:       rmux = {{(DATA_W-1){1'b0}}, run_q};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd;
         if (rd) rdata_q <= rmux;
      end
   end

   assign lim    = lim_q;
   assign run    = run_q;
   assign irq    = irq_q;
   assign rdata  = rdata_q;
   assign rvalid = rvalid_q;
endmodule

// File: rtl/proc_timer.sv
module proc_timer #(
   parameter int DATA_W   = 32,
   parameter int SUB_BITS = 9,
   parameter bit SNAP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              mode_stb,
   input  logic              mode_user,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [1:0]        bus_word,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              irq
);
   localparam int HI_W  = DATA_W - 1;
   localparam int LO_TW = DATA_W - SUB_BITS;
   localparam int USR_W = HI_W + LO_TW;
   localparam int CTR_W = DATA_W - 1 - SUB_BITS;

   generate
      if (DATA_W < 8 || SUB_BITS < 1 || SUB_BITS > DATA_W - 3) begin : g_bad_cfg
         $error("proc_timer: DATA_W/SUB_BITS out of range");
      end
   endgenerate

   logic             usr_q, chg, to_user;
   logic             run_q, ld_hi, ld_lo, clr, hit, adv;
   logic [CTR_W-1:0] lim_q;
   logic [USR_W-1:0] ticks_q;

   assign adv = tick_en && (!usr_q || run_q) && !(ld_hi || ld_lo || clr);

   proc_timer_mode u_mode (
      .clk(clk), .rst_n(rst_n), .mode_stb(mode_stb), .mode_user(mode_user),
      .usr(usr_q), .chg(chg), .to_user(to_user)
   );

   proc_timer_count #(.USR_W(USR_W), .CTR_W(CTR_W), .LO_TW(LO_TW), .HI_W(HI_W)) u_count (
      .clk(clk), .rst_n(rst_n), .adv(adv), .usr(usr_q),
      .ld_hi(ld_hi), .ld_lo(ld_lo), .clr(clr),
      .hi_val(bus_wdata[HI_W-1:0]), .lo_val(bus_wdata[DATA_W-1:SUB_BITS]),
      .lim(lim_q), .ticks(ticks_q), .hit(hit)
   );

   proc_timer_regs #(
      .DATA_W(DATA_W), .SUB_BITS(SUB_BITS), .USR_W(USR_W),
      .CTR_W(CTR_W), .LO_TW(LO_TW), .SNAP_EN(SNAP_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
      .lim_val(bus_wdata[DATA_W-2:SUB_BITS]), .run_val(bus_wdata[0]),
      .usr(usr_q), .chg(chg), .to_user(to_user), .hit(hit), .ticks(ticks_q),
      .lim(lim_q), .run(run_q), .ld_hi(ld_hi), .ld_lo(ld_lo), .clr(clr),
      .irq(irq), .rdata(bus_rdata), .rvalid(bus_rvalid)
   );
endmodule

// File: rtl/proc_timer_chk.sv
module proc_timer_chk #(
   parameter int DATA_W   = 32,
   parameter int SUB_BITS = 9,
   parameter int USR_W    = 54
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [1:0]        bus_word,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_rvalid,
   input logic              irq,
   input logic              usr,
   input logic              run,
   input logic [USR_W-1:0]  ticks,
   input logic              hit
);
   p_user_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      usr |-> !irq);

   p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we) |=> bus_rvalid);

   p_low_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_word == 2'd1) |=> (bus_rdata[SUB_BITS-1:0] == '0));

   p_ctrl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_word == 2'd3) |=> (bus_rdata[DATA_W-1:1] == '0));

   p_stopped_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (usr && !run && !(bus_sel && bus_we)) |=> $stable(ticks));

   p_limit_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!usr && bus_sel && !bus_we && bus_word == 2'd0 && !hit) |=> !irq);
endmodule

bind proc_timer proc_timer_chk #(.DATA_W(DATA_W), .SUB_BITS(SUB_BITS), .USR_W(USR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
   .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq),
   .usr(usr_q), .run(run_q), .ticks(ticks_q), .hit(hit)
);

// File: tb/proc_timer_test.sv
module proc_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, mode_stb = 1'b0, mode_user = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0]  bus_word = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid, irq;

   int checks = 0, failures = 0;

   // reference state, in tick units
   logic        m_usr, m_run, m_reached, m_irq, m_snapv;
   logic [21:0] m_lim;
   logic [53:0] m_ticks;
   logic [22:0] m_snap;

   always #2 clk = ~clk;

   proc_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_stb(mode_stb), .mode_user(mode_user),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic void model_tick();
      logic [53:0] top;
      if (m_usr || !m_run) begin
         if (!m_usr) begin end
      end
      if (!m_usr || m_run) begin
         if (m_usr)            top = 54'h3F_FFFF_FFFF_FFFE;
         else if (m_lim == 0)  top = 54'h3F_FFFE;
         else                  top = {32'd0, m_lim} - 54'd1;
         if (m_ticks >= top) begin
            m_ticks = '0;
            if (m_usr || m_lim != 0) m_reached = 1'b1;
            if (!m_usr && m_lim != 0) m_irq = 1'b1;
         end else begin
            m_ticks = m_ticks + 54'd1;
         end
      end
   endfunction

   function automatic logic [31:0] model_rd(int w);
      logic [31:0] r;
      case (w)
         0: if (m_usr) begin
               r = {m_reached, m_ticks[53:23]};
               m_snap = m_ticks[22:0]; m_snapv = 1'b1;
            end else begin
               r = {1'b0, m_lim, 9'd0};
               m_reached = 1'b0; m_irq = 1'b0;
            end
         1: if (m_usr) begin
               r = {(m_snapv ? m_snap : m_ticks[22:0]), 9'd0};
               m_snapv = 1'b0;
            end else begin
               r = {m_reached, m_ticks[21:0], 9'd0};
            end
         2: r = '0;
         default: r = {31'd0, m_run};
      endcase
      return r;
   endfunction

   function automatic void model_wr(int w, logic [31:0] d);
      if (w == 0 || w == 1) m_snapv = 1'b0;
      case (w)
         0: if (m_usr) begin m_ticks[53:23] = d[30:0]; m_reached = 1'b0; end
            else begin m_lim = d[30:9]; m_ticks = '0; m_irq = 1'b0; end
         1: if (m_usr) begin m_ticks[22:0] = d[31:9]; m_reached = 1'b0; end
         2: if (!m_usr) m_lim = d[30:9];
         default: m_run = d[0];
      endcase
   endfunction

   task automatic do_tick(int n);
      tick_en = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         model_tick();
      end
      tick_en = 1'b0;
   endtask

   task automatic bus_wr(int w, logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_word = w[1:0]; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      model_wr(w, d);
   endtask

   task automatic bus_rd(int w, string tag, output logic [31:0] got);
      logic [31:0] e;
      e = model_rd(w);
      bus_sel = 1'b1; bus_we = 1'b0; bus_word = w[1:0];
      @(negedge clk);
      bus_sel = 1'b0;
      got = bus_rdata;
      chk({tag, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
      chk({tag, " rdata"}, got, e);
   endtask

   task automatic set_mode(logic lvl);
      mode_user = lvl; mode_stb = 1'b1;
      @(negedge clk);
      mode_stb = 1'b0;
      if (lvl != m_usr) begin
         if (lvl) m_irq = 1'b0;
         m_usr = lvl; m_snapv = 1'b0;
      end
   endtask

   task automatic chk_irq(string tag);
      chk({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] g;
      int          op, w, sd;
      m_usr = 0; m_run = 1; m_reached = 0; m_irq = 0; m_snapv = 0;
      m_lim = '0; m_ticks = '0; m_snap = '0;
      sd = $urandom(32'd1357);
      repeat (3) @(negedge clk);
      chk("R1 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      bus_rd(0, "R1 limit", g);   chk("R1 limit lit", g, 32'h0);
      bus_rd(1, "R1 count", g);   chk("R1 count lit", g, 32'h0);
      bus_rd(3, "R1 run", g);     chk("R1 run lit", g, 32'h1);

      // R2 counter match with limit of 4 ticks
      bus_wr(0, 32'h0000_09FF);
      do_tick(3);
      bus_rd(1, "R2 count", g);   chk("R2 count lit", g, 32'h0000_0600);
      do_tick(1);
      chk("R2 irq lit", {31'd0, irq}, 32'd1);
      bus_rd(1, "R2 wrap", g);    chk("R2 wrap lit", g, 32'h8000_0000);

      // R4 limit read clears, word 2 keeps count
      bus_rd(0, "R4 limit", g);   chk("R4 limit lit", g, 32'h0000_0800);
      chk("R4 irq cleared", {31'd0, irq}, 32'd0);
      bus_rd(1, "R4 reached clr", g); chk("R4 reached lit", g, 32'h0);
      do_tick(2);
      bus_wr(2, 32'h0000_1400);
      bus_rd(1, "R4 no reset", g); chk("R4 no reset lit", g, 32'h0000_0400);
      do_tick(8);
      chk("R4 new limit irq", {31'd0, irq}, 32'd1);

      // R11 ignored writes and zero word
      bus_wr(1, 32'hFFFF_FFFF);
      bus_rd(1, "R11 w1 ignored", g); chk("R11 w1 ignored lit", g, 32'h8000_0000);
      bus_rd(2, "R11 w2 zero", g);    chk("R11 w2 lit", g, 32'h0);

      // R9 same-level strobe ignored, entering user lowers irq
      set_mode(1'b0);
      chk("R9 same level keeps irq", {31'd0, irq}, 32'd1);
      set_mode(1'b1);
      chk("R9 user lowers irq", {31'd0, irq}, 32'd0);

      // R5 / R6 user halves
      bus_wr(0, 32'h8000_0012);
      bus_wr(1, 32'hABCD_E1FF);
      bus_rd(0, "R6 hi", g);      chk("R6 hi lit", g, 32'h0000_0012);
      bus_rd(1, "R6 lo", g);      chk("R6 lo lit", g, 32'hABCD_E000);
      bus_wr(2, 32'h0000_0200);
      do_tick(1);
      bus_rd(0, "R5 hi", g);      chk("R5 hi lit", g, 32'h0000_0012);
      bus_rd(1, "R5 lo", g);      chk("R5 lo lit", g, 32'hABCD_E200);
      chk_irq("R5");

      // R7 user wrap
      bus_wr(0, 32'h7FFF_FFFF);
      bus_wr(1, 32'hFFFF_FC00);
      do_tick(1);
      chk("R7 no irq", {31'd0, irq}, 32'd0);
      bus_rd(0, "R7 hi", g);      chk("R7 hi lit", g, 32'h8000_0000);
      bus_rd(1, "R7 lo", g);      chk("R7 lo lit", g, 32'h0);

      // R10 snapshot across a carry
      bus_wr(0, 32'h0);
      bus_wr(1, 32'hFFFF_FE00);
      bus_rd(0, "R10 hi", g);     chk("R10 hi lit", g, 32'h0);
      do_tick(1);
      bus_rd(1, "R10 snap", g);   chk("R10 snap lit", g, 32'hFFFF_FE00);
      bus_rd(0, "R10 hi2", g);    chk("R10 hi2 lit", g, 32'h1);
      bus_rd(1, "R10 lo2", g);    chk("R10 lo2 lit", g, 32'h0);

      // R8 run bit
      bus_wr(3, 32'hFFFF_FFFE);
      bus_rd(3, "R8 run0", g);    chk("R8 run0 lit", g, 32'h0);
      do_tick(5);
      bus_rd(0, "R8 frozen hi", g); chk("R8 frozen hi lit", g, 32'h1);
      bus_rd(1, "R8 frozen lo", g); chk("R8 frozen lo lit", g, 32'h0);
      set_mode(1'b0);
      do_tick(3);
      bus_rd(1, "R9 resumes", g); chk("R8 counter runs lit", g, 32'h8000_0400);
      chk("R9 irq after resume", {31'd0, irq}, 32'd1);

      // R3 free-run wrap with limit zero
      bus_wr(0, 32'h0);
      bus_rd(0, "R3 clr", g);     chk("R3 clr lit", g, 32'h0);
      set_mode(1'b1);
      bus_wr(3, 32'h1);
      bus_wr(0, 32'h0);
      bus_wr(1, 32'h7FFF_FA00);
      set_mode(1'b0);
      do_tick(1);
      bus_rd(1, "R3 near top", g); chk("R3 near top lit", g, 32'h7FFF_FC00);
      do_tick(1);
      bus_rd(1, "R3 wrapped", g);  chk("R3 wrapped lit", g, 32'h0);
      chk("R3 no irq", {31'd0, irq}, 32'd0);

      // random mix, checked against the reference model (R2 R4 R5 R6 R8 R9 R10 R11)
      for (int k = 0; k < 400; k++) begin
         op = $urandom_range(0, 5);
         case (op)
            0, 1: do_tick($urandom_range(1, 6));
            2: begin
               w = $urandom_range(0, 3);
               if (!m_usr && (w == 0 || w == 2))
                  bus_wr(w, ($urandom_range(0, 12) << 9) | ($urandom & 32'h8000_01FF));
               else
                  bus_wr(w, $urandom);
            end
            3: bus_rd($urandom_range(0, 3), "RND read", g);
            4: set_mode(1'($urandom_range(0, 1)));
            default: bus_wr(3, {31'd0, 1'($urandom_range(0, 1))});
         endcase
         chk_irq("RND R2/R9");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule